// File: doc/BRIEF.md
# Line Driver Control and Fault Aggregator

This block is the digital control core of a serial line driver. It takes the raw status signals around the analog front end and turns them into the controls the driver stage acts on. The status signals are a signal-detect flag from the input qualifier, an unterminated-output flag from the amplitude comparator, an enable pin and an edge-rate pin. It also takes configuration fields held in a register file elsewhere. It produces four controls: the effective driver enable, the effective edge-rate select, the input-offset control and the output-mute control.

The block merges the two fault sources into one pull-down request for a shared open-drain fault line. Each source can be masked from that request. The live conditions and sticky copies of them are brought out so that a host can find which source raised the line. A termination fault counts only after the driver has stayed enabled for a qualification time, which defaults to 4 ms, so the output stage can settle first.

All pin inputs are asynchronous and pass through a synchronizer of `SYNC_STAGES` flops. The fault line request is registered one more time so that the line does not glitch. There is no streaming data path here. Every port is a plain level control or status signal.

Top module: `drv_ctl_fault`

## Requirements
- R1: While reset is held and on the first cycle after it, `fault_pull_o`, `lat_los_o`, `lat_term_o` and `st_term_o` are 0, and the synchronizers hold signal-detect as present (1) and every other pin as 0.
- R2: `drv_en_o` is 1 only when the synchronized `en_pin_i` is 1, and it is forced to 0 when `cfg_los_link_i` is 1 and signal-detect is 0.
- R3: `slow_edge_o` (1 = slow edges) is 1 whenever the synchronized `rate_pin_i` is 1. While the pin is 0, `slow_edge_o` equals `cfg_rate_slow_i`.
- R4: While signal-detect is 0, `cfg_los_mute_i` = 0 (the reset default) sets `in_offset_o`, and `cfg_los_mute_i` = 1 sets `out_mute_o` instead. Both are 0 while signal-detect is 1, and they are never both 1.
- R5: A loss of signal (signal-detect 0) requests a pull-down on the fault line (`fault_pull_o` = 1) unless `cfg_mask_los_i` is 1.
- R6: A qualified termination fault requests a pull-down on the fault line unless `cfg_mask_term_i` is 1.
- R7: A termination fault is qualified only while `drv_en_o` is 1 and after `drv_en_o` has been 1 without a break for QUAL_US microseconds (QUAL_US × CLK_HZ / 10^6 cycles). Any drop of `drv_en_o` restarts that count.
- R8: `st_los_o` and `st_term_o` show the live loss-of-signal and qualified termination-fault conditions whatever the mask bits are set to.
- R9: `st_term_o` returns to 0 as soon as the comparator flag clears. `lat_los_o` and `lat_term_o` are set by their live condition and stay set until a `clr_los_i` or `clr_term_i` pulse arrives at a time when the condition is absent. If set and clear come in the same cycle, set wins.
- R10: With the default of two synchronizer stages, a pin change first shows on the control and status outputs after two rising clock edges, and on `fault_pull_o` after three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_det_i | input | 1 | 1 = valid input signal present, 0 = loss of signal (async) |
| term_flt_i | input | 1 | 1 = comparator sees unterminated output (async) |
| en_pin_i | input | 1 | Driver enable pin (async) |
| rate_pin_i | input | 1 | Edge-rate pin, 1 = slow (async, pulled low externally) |
| cfg_los_mute_i | input | 1 | Loss reaction: 0 = input offset, 1 = output mute |
| cfg_los_link_i | input | 1 | 1 = loss of signal forces the driver disabled |
| cfg_rate_slow_i | input | 1 | Register edge-rate choice, used while the pin is low |
| cfg_mask_los_i | input | 1 | 1 = keep loss of signal off the fault line |
| cfg_mask_term_i | input | 1 | 1 = keep termination fault off the fault line |
| clr_los_i | input | 1 | Pulse that clears the sticky loss bit |
| clr_term_i | input | 1 | Pulse that clears the sticky termination bit |
| drv_en_o | output | 1 | Effective driver enable |
| slow_edge_o | output | 1 | Effective edge-rate select, 1 = slow |
| in_offset_o | output | 1 | Add input offset |
| out_mute_o | output | 1 | Mute driver output |
| fault_pull_o | output | 1 | 1 = pull the shared open-drain fault line low |
| st_los_o | output | 1 | Live loss-of-signal status |
| st_term_o | output | 1 | Live qualified termination-fault status |
| lat_los_o | output | 1 | Sticky loss-of-signal status |
| lat_term_o | output | 1 | Sticky termination-fault status |

## Verification
An error in the qualification counter shows up as `st_term_o` rising too early after enable, never rising, or not restarting when a loss of signal coupled to enable pulls the driver down. The bench therefore checks `st_term_o` at about half the qualification window and again just after the window ends. Errors in the mask, reaction or arbitration logic show at the ports two clock edges after the pin change that reveals them. An error in the fault register shows one edge after that. A sticky bit that is not held or not cleared properly stays visible until the next clear pulse.

// File: rtl/drvctl_pkg.sv
package drvctl_pkg;

  typedef enum logic {
    LOS_REACT_OFFSET = 1'b0,
    LOS_REACT_MUTE   = 1'b1
  } los_react_e;

  // synchronized pin bundle positions
  localparam int PIN_SIG  = 0;
  localparam int PIN_TERM = 1;
  localparam int PIN_EN   = 2;
  localparam int PIN_RATE = 3;
  localparam int PIN_W    = 4;

  function automatic int qual_cycles(input int clk_hz, input int qual_us);
    longint prod;
    prod = longint'(clk_hz) * longint'(qual_us) / 64'd1000000;
    if (prod < 1) prod = 1;
    return int'(prod);
  endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int           W       = 4,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/dcf_qual_timer.sv
module dcf_qual_timer #(
  parameter int QUAL_CYC = 400000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic qual_o
);
  localparam int CW = $clog2(QUAL_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(QUAL_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!en_i)          cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign qual_o = (cnt_q == LIMIT);

  // R7: a drop of enable restarts the window
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0));
  // R7: qualification cannot appear without enable having been high
  a_r7_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qual_o) |-> $past(en_i));
endmodule

// File: rtl/dcf_fault_merge.sv
module dcf_fault_merge (
  input  logic clk,
  input  logic rst_n,
  input  logic los_act_i,
  input  logic term_act_i,
  input  logic mask_los_i,
  input  logic mask_term_i,
  input  logic clr_los_i,
  input  logic clr_term_i,
  output logic fault_pull_o,
  output logic lat_los_o,
  output logic lat_term_o
);
  logic src_los, src_term;

  assign src_los  = los_act_i  & ~mask_los_i;
  assign src_term = term_act_i & ~mask_term_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_pull_o <= 1'b0;
      lat_los_o    <= 1'b0;
      lat_term_o   <= 1'b0;
    end else begin
      fault_pull_o <= src_los | src_term;
      lat_los_o    <= los_act_i  | (lat_los_o  & ~clr_los_i);
      lat_term_o   <= term_act_i | (lat_term_o & ~clr_term_i);
    end
  end

  // R9: a live condition always leaves its sticky bit set
  a_r9_los_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    los_act_i |=> lat_los_o);
  a_r9_term_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    term_act_i |=> lat_term_o);
  // R5 / R6: the line is pulled only for an unmasked source
  a_r5_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_pull_o) |-> $past((los_act_i && !mask_los_i) || (term_act_i && !mask_term_i)));
endmodule

// File: rtl/drv_ctl_fault.sv
module drv_ctl_fault
  import drvctl_pkg::*;
#(
  parameter int CLK_HZ      = 100000000,
  parameter int QUAL_US     = 4000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_det_i,
  input  logic term_flt_i,
  input  logic en_pin_i,
  input  logic rate_pin_i,
  input  logic cfg_los_mute_i,
  input  logic cfg_los_link_i,
  input  logic cfg_rate_slow_i,
  input  logic cfg_mask_los_i,
  input  logic cfg_mask_term_i,
  input  logic clr_los_i,
  input  logic clr_term_i,
  output logic drv_en_o,
  output logic slow_edge_o,
  output logic in_offset_o,
  output logic out_mute_o,
  output logic fault_pull_o,
  output logic st_los_o,
  output logic st_term_o,
  output logic lat_los_o,
  output logic lat_term_o
);
  localparam int QUAL_CYC = qual_cycles(CLK_HZ, QUAL_US);
  localparam logic [PIN_W-1:0] PIN_RST = PIN_W'(1) << PIN_SIG;

  logic [PIN_W-1:0] pin_raw, pin_s;
  logic             los_act, term_live, qual;
  los_react_e       react;

  assign pin_raw[PIN_SIG]  = sig_det_i;
  assign pin_raw[PIN_TERM] = term_flt_i;
  assign pin_raw[PIN_EN]   = en_pin_i;
  assign pin_raw[PIN_RATE] = rate_pin_i;

  dcf_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_raw),
    .q_o   (pin_s)
  );

  assign los_act = ~pin_s[PIN_SIG];
  assign react   = los_react_e'(cfg_los_mute_i);

  always_comb begin
    drv_en_o    = pin_s[PIN_EN] & ~(cfg_los_link_i & los_act);
    slow_edge_o = pin_s[PIN_RATE] ? 1'b1 : cfg_rate_slow_i;
    in_offset_o = 1'b0;
    out_mute_o  = 1'b0;
    if (los_act) begin
      case (react)
        LOS_REACT_MUTE: out_mute_o  = 1'b1;
        default:        in_offset_o = 1'b1;
      endcase
    end
  end

  dcf_qual_timer #(.QUAL_CYC(QUAL_CYC)) u_qual (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (drv_en_o),
    .qual_o (qual)
  );

  assign term_live = pin_s[PIN_TERM] & drv_en_o & qual;
  assign st_los_o  = los_act;
  assign st_term_o = term_live;

  dcf_fault_merge u_merge (
    .clk          (clk),
    .rst_n        (rst_n),
    .los_act_i    (los_act),
    .term_act_i   (term_live),
    .mask_los_i   (cfg_mask_los_i),
    .mask_term_i  (cfg_mask_term_i),
    .clr_los_i    (clr_los_i),
    .clr_term_i   (clr_term_i),
    .fault_pull_o (fault_pull_o),
    .lat_los_o    (lat_los_o),
    .lat_term_o   (lat_term_o)
  );

  // R2: loss coupled to enable keeps the driver off
  a_r2_link_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_los_link_i && !pin_s[PIN_SIG]) |-> !drv_en_o);
  // R3: pin high always selects slow edges
  a_r3_pin_slow: assert property (@(posedge clk) disable iff (!rst_n)
    pin_s[PIN_RATE] |-> slow_edge_o);
  // R4: offset and mute never together
  a_r4_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_offset_o && out_mute_o));
  // R7: termination status only while driving
  a_r7_term_gate: assert property (@(posedge clk) disable iff (!rst_n)
    st_term_o |-> drv_en_o);
endmodule

// File: tb/drv_ctl_fault_tb.sv
module drv_ctl_fault_tb;
  localparam int QUAL = 40; // CLK_HZ 1 MHz * 40 us

  logic clk = 1'b0, rst_n = 1'b0;
  logic sig_det, term_flt, en_pin, rate_pin;
  logic cfg_mute, cfg_link, cfg_rate, mask_los, mask_term, clr_los, clr_term;
  logic drv_en, slow_edge, in_offset, out_mute, fault_pull, st_los, st_term, lat_los, lat_term;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  drv_ctl_fault #(.CLK_HZ(1000000), .QUAL_US(40), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .sig_det_i(sig_det), .term_flt_i(term_flt),
    .en_pin_i(en_pin), .rate_pin_i(rate_pin), .cfg_los_mute_i(cfg_mute),
    .cfg_los_link_i(cfg_link), .cfg_rate_slow_i(cfg_rate), .cfg_mask_los_i(mask_los),
    .cfg_mask_term_i(mask_term), .clr_los_i(clr_los), .clr_term_i(clr_term),
    .drv_en_o(drv_en), .slow_edge_o(slow_edge), .in_offset_o(in_offset),
    .out_mute_o(out_mute), .fault_pull_o(fault_pull), .st_los_o(st_los),
    .st_term_o(st_term), .lat_los_o(lat_los), .lat_term_o(lat_term));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // inputs {sig,en,rate,mute,link,creg,mlos} ; expect {drv_en,slow,offset,mute,fault,st_los}
  localparam int NV = 11;
  localparam logic [12:0] VEC [NV] = '{
    {7'b1100000, 6'b100000},
    {7'b1110000, 6'b110000},
    {7'b1100010, 6'b110000},
    {7'b0100000, 6'b101011},
    {7'b0101000, 6'b100111},
    {7'b0100001, 6'b101001},
    {7'b0100100, 6'b001011},
    {7'b1100100, 6'b100000},
    {7'b1000000, 6'b000000},
    {7'b1110010, 6'b110000},
    {7'b0011111, 6'b010101}
  };

  initial begin : watchdog
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    sig_det = 1; term_flt = 0; en_pin = 0; rate_pin = 0;
    cfg_mute = 0; cfg_link = 0; cfg_rate = 0; mask_los = 0; mask_term = 0;
    clr_los = 0; clr_term = 0;
    cyc(3);
    // R1 during reset
    chk("R1 fault", fault_pull, 1'b0); chk("R1 lat_los", lat_los, 1'b0);
    chk("R1 lat_term", lat_term, 1'b0); chk("R1 st_term", st_term, 1'b0);
    chk("R1 st_los", st_los, 1'b0); chk("R1 drv_en", drv_en, 1'b0);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 fault after", fault_pull, 1'b0); chk("R1 lat_los after", lat_los, 1'b0);

    for (int v = 0; v < NV; v++) begin
      {sig_det, en_pin, rate_pin, cfg_mute, cfg_link, cfg_rate, mask_los} = VEC[v][12:6];
      cyc(4);
      chk("R2 drv_en",  drv_en,     VEC[v][5]);
      chk("R3 slow",    slow_edge,  VEC[v][4]);
      chk("R4 offset",  in_offset,  VEC[v][3]);
      chk("R4 mute",    out_mute,   VEC[v][2]);
      chk("R5 fault",   fault_pull, VEC[v][1]);
      chk("R8 st_los",  st_los,     VEC[v][0]);
    end

    // R9 sticky loss bit, then clear
    sig_det = 1; en_pin = 1; rate_pin = 0; cfg_mute = 0; cfg_link = 0; cfg_rate = 0; mask_los = 0;
    cyc(4);
    chk("R9 lat_los held", lat_los, 1'b1);
    clr_los = 1; cyc(1); clr_los = 0; cyc(1);
    chk("R9 lat_los cleared", lat_los, 1'b0);

    // R10 latency of pins and fault register
    sig_det = 0;
    cyc(1);
    chk("R10 st_los after 1 edge", st_los, 1'b0);
    cyc(1);
    chk("R10 st_los after 2 edges", st_los, 1'b1);
    chk("R10 fault after 2 edges", fault_pull, 1'b0);
    cyc(1);
    chk("R10 fault after 3 edges", fault_pull, 1'b1);
    sig_det = 1; cyc(4);
    clr_los = 1; cyc(1); clr_los = 0;

    // R7 qualification window after enable
    en_pin = 0; cyc(4);
    term_flt = 1; en_pin = 1;
    cyc(QUAL / 2);
    chk("R7 early st_term", st_term, 1'b0);
    chk("R6 early fault", fault_pull, 1'b0);
    cyc(QUAL / 2 + 8);
    chk("R7 qualified st_term", st_term, 1'b1);
    chk("R6 term fault", fault_pull, 1'b1);
    chk("R9 lat_term set", lat_term, 1'b1);
    // R6/R8 mask hides the line but not the status
    mask_term = 1; cyc(2);
    chk("R6 masked fault", fault_pull, 1'b0);
    chk("R8 st_term masked", st_term, 1'b1);
    mask_term = 0;
    // R9 non-sticky live, sticky latch
    term_flt = 0; cyc(4);
    chk("R9 st_term clears", st_term, 1'b0);
    chk("R9 lat_term held", lat_term, 1'b1);
    chk("R6 fault released", fault_pull, 1'b0);
    clr_term = 1; cyc(1); clr_term = 0; cyc(1);
    chk("R9 lat_term cleared", lat_term, 1'b0);

    // R7 restart through loss coupled to enable
    term_flt = 1; cyc(4);
    chk("R7 term back", st_term, 1'b1);
    cfg_link = 1; sig_det = 0; cyc(4);
    chk("R2 link drops enable", drv_en, 1'b0);
    chk("R7 gated when off", st_term, 1'b0);
    sig_det = 1; cyc(QUAL / 2);
    chk("R7 restarted", st_term, 1'b0);
    cyc(QUAL / 2 + 8);
    chk("R7 requalified", st_term, 1'b1);
    en_pin = 0; cyc(4);
    chk("R7 pin off gates", st_term, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule